// File: doc/BRIEF.md
# Multicycle 16-bit Processor Core

This block is a small accumulator-free processor core that runs one instruction at a time through a fixed sequence of states. It holds eight 16-bit general registers, a 12-bit program counter, an instruction register, an address register, a data register, two operand buffers and a sticky halt flag. Instructions are 16 bits wide and are read from a 256-byte memory through a synchronous port. Words are stored big-endian: the even byte holds bits [15:8]. The memory returns read data one cycle after the read strobe.

Eleven instructions are executed: exit, load, store, add, subtract, multiply, divide, jump, jump-if-zero, jump-if-negative and move. One memory address, 254, is routed to an integer console instead of memory. A load from it waits on a valid/ready input port. A store to it raises a one-cycle valid on an output port. The core stops for good when an exit executes, when an arithmetic result overflows, when a divide has a zero divisor, or when the program counter steps past its top value.

States and transitions: `ST_FETCH_A` (address register takes PC) → `ST_FETCH_R` (read strobe) → `ST_FETCH_M` (data register captures the word) → `ST_FETCH_I` (instruction register loads, PC += 2; a carry out goes to `ST_HALT`, otherwise to `ST_DECODE`). From `ST_DECODE` the opcode selects one of these paths:
- exit → `ST_HALT`.
- add/sub/mul/div → `ST_OPND` → `ST_EXEC` → `ST_FETCH_A`, or `ST_HALT` on overflow or a zero divisor.
- move → `ST_MOVE` → `ST_FETCH_A`.
- load/store → `ST_ADDR` → `ST_ROUTE`, which branches four ways:
  - `ST_LD_R` → `ST_LD_M` → `ST_LD_W` → `ST_FETCH_A`
  - `ST_ST_W` → `ST_FETCH_A`
  - `ST_CIN` (holds until input valid) → `ST_FETCH_A`
  - `ST_COUT` → `ST_FETCH_A`
- jump → `ST_JUMP` → `ST_FETCH_A`.
- conditional jumps → `ST_TEST` → `ST_JUMP` or `ST_FETCH_A`.
- unused opcodes → `ST_FETCH_A`.

`ST_HALT` is terminal.

Top module: `mc16_core`

## Requirements
- R1: During and right after reset, halted, console output valid, console input ready and the memory write strobe are low. The first memory read after reset is at address 0.
- R2: Instruction bits [15:11] are the opcode, [10:8] the first register, [7:5] the second register and [7:0] the address. Each fetch reads one big-endian word at PC, then PC advances by 2. Opcodes 0x0B to 0x1F do nothing beyond their fetch.
- R3: A fetch from PC 0xFFE carries out of the 12-bit PC and halts the core before that instruction executes. A program made only of unused opcodes therefore performs exactly 2048 fetches after reset.
- R4: Add (opcode 3) and subtract (opcode 4) write first-register ± second-register into the first register. A signed 16-bit overflow halts the core instead, and no later instruction runs.
- R5: Multiply (opcode 5) writes the signed 16-bit product. A product outside the signed 16-bit range halts the core.
- R6: Divide (opcode 6) writes the signed quotient truncated toward zero. A zero divisor, or -32768 divided by -1, halts the core.
- R7: Load (opcode 1) and store (opcode 2) with an address other than 254 read or write the big-endian word at that byte address. The read and write strobes are never high together.
- R8: A load from address 254 holds console input ready high until input valid is seen. It writes the input data into the first register in the cycle both are high.
- R9: A store to address 254 raises console output valid for exactly one cycle, carrying the first register's value. Memory is not written for that address.
- R10: Jump (opcode 7) sets PC to the 8-bit address field, with the upper PC bits cleared.
- R11: Jump-if-zero (opcode 8) branches only when the first register is 0. Jump-if-negative (opcode 9) branches only when its bit 15 is 1. Otherwise execution falls through to the next word.
- R12: Move (opcode 0x0A) copies the second register into the first. Exit (opcode 0) halts. Once halted, the flag stays high and no memory or console strobe rises until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Byte address of the word access |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe for a word |
| mem_wdata | output | 16 | Write data, bits [15:8] to the even byte |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| con_in_valid | input | 1 | Console input word offered |
| con_in_data | input | 16 | Console input word |
| con_in_ready | output | 1 | Core waits for a console word |
| con_out_valid | output | 1 | One-cycle console output strobe |
| con_out_data | output | 16 | Console output word |
| halted | output | 1 | Sticky halt flag |

## Verification
Most internal faults surface at the console within one instruction. A wrong operand, result or register write changes the value of the next console store, and a wrong overflow decision either suppresses that store or lets it through. A mistaken branch, PC step or opcode decode changes how many console words appear before halt, or how many fetches precede it. The PC carry is seen only after 2048 fetches, so that sweep is run in full. Console handshake faults show up the same cycle as a missing ready, a stretched output pulse or a stalled load.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

    // instruction field layout (fixed by the 16-bit format)
    localparam int OP_LSB   = 11;
    localparam int OP_W     = 5;
    localparam int F1_LSB   = 8;
    localparam int F2_LSB   = 5;
    localparam int ADDR_W   = 8;

    localparam logic [OP_W-1:0] OP_EXIT  = 5'd0;
    localparam logic [OP_W-1:0] OP_LOAD  = 5'd1;
    localparam logic [OP_W-1:0] OP_STORE = 5'd2;
    localparam logic [OP_W-1:0] OP_ADD   = 5'd3;
    localparam logic [OP_W-1:0] OP_SUB   = 5'd4;
    localparam logic [OP_W-1:0] OP_MUL   = 5'd5;
    localparam logic [OP_W-1:0] OP_DIV   = 5'd6;
    localparam logic [OP_W-1:0] OP_JMP   = 5'd7;
    localparam logic [OP_W-1:0] OP_JMPZ  = 5'd8;
    localparam logic [OP_W-1:0] OP_JMPN  = 5'd9;
    localparam logic [OP_W-1:0] OP_MOVE  = 5'd10;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_MUL,
        ALU_DIV
    } alu_op_e;

    typedef enum logic [4:0] {
        ST_FETCH_A,
        ST_FETCH_R,
        ST_FETCH_M,
        ST_FETCH_I,
        ST_DECODE,
        ST_OPND,
        ST_EXEC,
        ST_MOVE,
        ST_ADDR,
        ST_ROUTE,
        ST_LD_R,
        ST_LD_M,
        ST_LD_W,
        ST_ST_W,
        ST_CIN,
        ST_COUT,
        ST_TEST,
        ST_JUMP,
        ST_HALT
    } state_e;

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
    parameter int W = 16,
    parameter int N = 8,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] ra,
    input  logic [SW-1:0] rb,
    output logic [W-1:0]  rda,
    output logic [W-1:0]  rdb
);

    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && (waddr == SW'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rda = regs[ra];
    assign rdb = regs[rb];

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
    import mc16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         ovf,
    output logic         div0
);

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W:0]     sum_ext;
    logic [W:0]     dif_ext;
    logic [2*W-1:0] prod;
    logic [W-1:0]   dsafe;
    logic [W-1:0]   quot;
    logic           div_edge;

    assign sum_ext  = {a[W-1], a} + {b[W-1], b};
    assign dif_ext  = {a[W-1], a} - {b[W-1], b};
    assign prod     = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    assign dsafe    = (b == '0) ? W'(1) : b;
    assign quot     = $signed(a) / $signed(dsafe);
    assign div_edge = (a == MOST_NEG) && (b == '1);

    always_comb begin
        y    = a;
        ovf  = 1'b0;
        div0 = 1'b0;
        unique case (op)
            ALU_ADD: begin
                y   = sum_ext[W-1:0];
                ovf = sum_ext[W] ^ sum_ext[W-1];
            end
            ALU_SUB: begin
                y   = dif_ext[W-1:0];
                ovf = dif_ext[W] ^ dif_ext[W-1];
            end
            ALU_MUL: begin
                y   = prod[W-1:0];
                ovf = (prod[2*W-1:W-1] != {(W+1){prod[W-1]}});
            end
            ALU_DIV: begin
                div0 = (b == '0);
                if (div_edge) begin
                    y   = a;
                    ovf = 1'b1;
                end else begin
                    y = quot;
                end
            end
            default: y = a;
        endcase
    end

endmodule

// File: rtl/mc16_core.sv
module mc16_core
    import mc16_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PC_W     = 12,
    parameter int NREGS    = 8,
    parameter int MEM_AW   = 8,
    parameter int CON_ADDR = 254
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              con_in_valid,
    input  logic [DATA_W-1:0] con_in_data,
    output logic              con_in_ready,
    output logic              con_out_valid,
    output logic [DATA_W-1:0] con_out_data,
    output logic              halted
);

    localparam int RSEL_W = $clog2(NREGS);

    state_e            state_q, state_d;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   mar_q;
    logic [DATA_W-1:0] mdr_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] buf1_q;
    logic [DATA_W-1:0] buf2_q;
    logic              halt_q;

    logic [OP_W-1:0]   ir_op;
    logic [RSEL_W-1:0] f1, f2;
    logic [ADDR_W-1:0] ir_addr;
    logic [PC_W:0]     pc_inc;
    logic              to_console;

    logic              rf_we;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] rda, rdb;

    alu_op_e           alu_op;
    logic [DATA_W-1:0] alu_y;
    logic              alu_ovf, alu_div0;
    logic              take_branch;

    assign ir_op      = ir_q[OP_LSB +: OP_W];
    assign f1         = ir_q[F1_LSB +: RSEL_W];
    assign f2         = ir_q[F2_LSB +: RSEL_W];
    assign ir_addr    = ir_q[ADDR_W-1:0];
    assign pc_inc     = {1'b0, pc_q} + (PC_W+1)'(2);
    assign to_console = (mar_q == PC_W'(CON_ADDR));

    mc16_regfile #(.W(DATA_W), .N(NREGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (f1),
        .wdata (rf_wdata),
        .ra    (f1),
        .rb    (f2),
        .rda   (rda),
        .rdb   (rdb)
    );

    always_comb begin
        unique case (ir_op)
            OP_SUB:  alu_op = ALU_SUB;
            OP_MUL:  alu_op = ALU_MUL;
            OP_DIV:  alu_op = ALU_DIV;
            default: alu_op = ALU_ADD;
        endcase
    end

    mc16_alu #(.W(DATA_W)) u_alu (
        .op   (alu_op),
        .a    (buf1_q),
        .b    (buf2_q),
        .y    (alu_y),
        .ovf  (alu_ovf),
        .div0 (alu_div0)
    );

    always_comb begin
        if (ir_op == OP_JMPZ) begin
            take_branch = (rda == '0);
        end else begin
            take_branch = rda[DATA_W-1];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH_A;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_A: state_d = ST_FETCH_R;
            ST_FETCH_R: state_d = ST_FETCH_M;
            ST_FETCH_M: state_d = ST_FETCH_I;
            ST_FETCH_I: state_d = pc_inc[PC_W] ? ST_HALT : ST_DECODE;
            ST_DECODE: begin
                unique case (ir_op)
                    OP_EXIT:                        state_d = ST_HALT;
                    OP_LOAD, OP_STORE:              state_d = ST_ADDR;
                    OP_ADD, OP_SUB, OP_MUL, OP_DIV: state_d = ST_OPND;
                    OP_JMP:                         state_d = ST_JUMP;
                    OP_JMPZ, OP_JMPN:               state_d = ST_TEST;
                    OP_MOVE:                        state_d = ST_MOVE;
                    default:                        state_d = ST_FETCH_A;
                endcase
            end
            ST_OPND:  state_d = ST_EXEC;
            ST_EXEC:  state_d = (alu_ovf || alu_div0) ? ST_HALT : ST_FETCH_A;
            ST_MOVE:  state_d = ST_FETCH_A;
            ST_ADDR:  state_d = ST_ROUTE;
            ST_ROUTE: begin
                if (ir_op == OP_LOAD) begin
                    state_d = to_console ? ST_CIN : ST_LD_R;
                end else begin
                    state_d = to_console ? ST_COUT : ST_ST_W;
                end
            end
            ST_LD_R:  state_d = ST_LD_M;
            ST_LD_M:  state_d = ST_LD_W;
            ST_LD_W:  state_d = ST_FETCH_A;
            ST_ST_W:  state_d = ST_FETCH_A;
            ST_CIN:   state_d = con_in_valid ? ST_FETCH_A : ST_CIN;
            ST_COUT:  state_d = ST_FETCH_A;
            ST_TEST:  state_d = take_branch ? ST_JUMP : ST_FETCH_A;
            ST_JUMP:  state_d = ST_FETCH_A;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd        = 1'b0;
        mem_wr        = 1'b0;
        con_in_ready  = 1'b0;
        con_out_valid = 1'b0;
        rf_we         = 1'b0;
        rf_wdata      = alu_y;
        unique case (state_q)
            ST_FETCH_R, ST_LD_R: mem_rd = 1'b1;
            ST_ST_W:             mem_wr = 1'b1;
            ST_COUT:             con_out_valid = 1'b1;
            ST_EXEC: begin
                rf_we    = !alu_div0;
                rf_wdata = alu_y;
            end
            ST_MOVE: begin
                rf_we    = 1'b1;
                rf_wdata = rdb;
            end
            ST_LD_W: begin
                rf_we    = 1'b1;
                rf_wdata = mdr_q;
            end
            ST_CIN: begin
                con_in_ready = 1'b1;
                rf_we        = con_in_valid;
                rf_wdata     = con_in_data;
            end
            default: ;
        endcase
    end

    assign mem_addr     = mar_q[MEM_AW-1:0];
    assign mem_wdata    = buf1_q;
    assign con_out_data = buf1_q;
    assign halted       = halt_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            mar_q  <= '0;
            mdr_q  <= '0;
            ir_q   <= '0;
            buf1_q <= '0;
            buf2_q <= '0;
            halt_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH_A: mar_q <= pc_q;
                ST_FETCH_M: mdr_q <= mem_rdata;
                ST_FETCH_I: begin
                    ir_q <= mdr_q;
                    pc_q <= pc_inc[PC_W-1:0];
                    if (pc_inc[PC_W]) halt_q <= 1'b1;
                end
                ST_DECODE: begin
                    if (ir_op == OP_EXIT) halt_q <= 1'b1;
                end
                ST_OPND: begin
                    buf1_q <= rda;
                    buf2_q <= rdb;
                end
                ST_EXEC: begin
                    if (alu_ovf || alu_div0) halt_q <= 1'b1;
                end
                ST_ADDR: begin
                    mar_q  <= {{(PC_W-ADDR_W){1'b0}}, ir_addr};
                    buf1_q <= rda;
                end
                ST_LD_M: mdr_q <= mem_rdata;
                ST_JUMP: pc_q  <= {{(PC_W-ADDR_W){1'b0}}, ir_addr};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halted,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic [7:0] mem_addr,
    input logic       con_in_ready,
    input logic       con_in_valid,
    input logic       con_out_valid
);

    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(mem_rd || mem_wr || con_out_valid || con_in_ready));

    assert_out_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        con_out_valid |=> !con_out_valid);

    assert_no_wr_console_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr != 8'd254));

    assert_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (con_in_ready && !con_in_valid) |=> con_in_ready);

    assert_rd_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

bind mc16_core mc16_core_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .halted        (halted),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .mem_addr      (mem_addr),
    .con_in_ready  (con_in_ready),
    .con_in_valid  (con_in_valid),
    .con_out_valid (con_out_valid)
);

// File: tb/mc16_core_bench.sv
`timescale 1ns/1ps
module mc16_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        con_in_valid = 1'b0;
    logic [15:0] con_in_data = '0;
    logic        con_in_ready, con_out_valid;
    logic [15:0] con_out_data;
    logic        halted;

    always #2.5 clk = ~clk;

    mc16_core u_mc16_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_addr      (mem_addr),
        .mem_rd        (mem_rd),
        .mem_wr        (mem_wr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .con_in_valid  (con_in_valid),
        .con_in_data   (con_in_data),
        .con_in_ready  (con_in_ready),
        .con_out_valid (con_out_valid),
        .con_out_data  (con_out_data),
        .halted        (halted)
    );

    // byte memory, big-endian words, one-cycle read latency
    logic [7:0] mem [256];
    always @(posedge clk) begin
        logic [7:0] nxt;
        nxt = mem_addr + 8'd1;
        if (mem_rd) mem_rdata <= {mem[mem_addr], mem[nxt]};
        if (mem_wr) begin
            mem[mem_addr] = mem_wdata[15:8];
            mem[nxt]      = mem_wdata[7:0];
        end
    end

    int tests = 0;
    int fails = 0;
    int total_cyc = 0;
    always @(posedge clk) total_cyc <= total_cyc + 1;

    logic [15:0] in_vals [4];
    logic [15:0] out_vals [8];
    int out_cnt, fetch_cnt, stall_cnt, first_rd;
    bit timed_out, quiet_bad, reset_bad;

    int vals [16] = '{0, 1, -1, 2, -2, 7, -7, 100, -100, 255,
                      32767, -32768, 16384, -16384, 181, -182};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic fill(input logic [7:0] b);
        for (int i = 0; i < 256; i++) mem[i] = b;
    endtask

    task automatic put(input int a, input logic [15:0] w);
        mem[a]     = w[15:8];
        mem[a + 1] = w[7:0];
    endtask

    task automatic run_prog(input int max_cyc, input int gap);
        int  idx;
        int  stall;
        bit  take;
        out_cnt = 0; fetch_cnt = 0; stall_cnt = 0; first_rd = -1;
        timed_out = 1; quiet_bad = 0; reset_bad = 0;
        idx = 0; stall = gap;
        @(negedge clk);
        rst_n = 1'b0;
        con_in_valid = 1'b0;
        con_in_data = in_vals[0];
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (halted || con_out_valid || con_in_ready || mem_wr) reset_bad = 1;
        rst_n = 1'b1;
        for (int c = 0; c < max_cyc; c++) begin
            @(negedge clk);
            take = 0;
            if (con_in_ready && stall > 0) begin
                stall--;
                stall_cnt++;
                con_in_valid = 1'b0;
            end else begin
                con_in_valid = 1'b1;
                take = con_in_ready;
            end
            if (mem_rd) begin
                fetch_cnt++;
                if (first_rd < 0) first_rd = int'(mem_addr);
            end
            if (con_out_valid && out_cnt < 8) begin
                out_vals[out_cnt] = con_out_data;
                out_cnt++;
            end
            if (halted) begin
                timed_out = 0;
                break;
            end
            @(posedge clk);
            #1;
            if (take && idx < 3) begin
                idx++;
                con_in_data = in_vals[idx];
            end
        end
        for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || con_out_valid || con_in_ready || !halted) quiet_bad = 1;
        end
    endtask

    function automatic void exp_alu(input int op, input int a, input int b,
                                    output bit h, output int r);
        h = 0; r = 0;
        case (op)
            3: r = a + b;
            4: r = a - b;
            5: r = a * b;
            default: begin
                if (b == 0) h = 1;
                else r = a / b;
            end
        endcase
        if (r > 32767 || r < -32768) h = 1;
    endfunction

    initial begin : watchdog
        wait (total_cyc >= 190000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected below 190000", total_cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        bit h; int r; bit tk; int ac;

        // R1 / R12: exit at address 0
        fill(8'h00);
        in_vals = '{default: 16'h0};
        run_prog(100, 0);
        chk(!reset_bad, "R1 reset outputs", reset_bad, 0);
        chk(first_rd == 0, "R1 first fetch address", first_rd, 0);
        chk(!timed_out && fetch_cnt == 1 && out_cnt == 0, "R12 exit halts", fetch_cnt, 1);
        chk(!quiet_bad, "R12 quiet after halt", quiet_bad, 0);

        // R2: unused opcodes are no-ops, PC steps by 2
        fill(8'h00);
        put(0, 16'h0AFE);   // load R2 <- console
        put(2, 16'h5FFF);   // opcode 0x0B
        put(4, 16'hFFFF);   // opcode 0x1F
        put(6, 16'h12FE);   // store R2 -> console
        put(8, 16'h0000);
        in_vals = '{16'hA55A, 16'h0, 16'h0, 16'h0};
        run_prog(200, 0);
        chk(out_cnt == 1 && out_vals[0] == 16'hA55A, "R2 no-op opcodes", int'(out_vals[0]), 'hA55A);
        chk(fetch_cnt == 5, "R2 fetch count", fetch_cnt, 5);

        // R3: PC carry after 2048 fetches of no-ops
        fill(8'hF8);
        run_prog(12000, 0);
        chk(!timed_out && fetch_cnt == 2048, "R3 pc overflow fetches", fetch_cnt, 2048);
        chk(out_cnt == 0, "R3 no output", out_cnt, 0);

        // R7 / R9: memory load/store big-endian, console store leaves memory alone
        fill(8'h00);
        mem[8'h40] = 8'hBE; mem[8'h41] = 8'hEF;
        put(0, 16'h0B40);   // load R3, 0x40
        put(2, 16'h1350);   // store R3, 0x50
        put(4, 16'h13FE);   // store R3 -> console
        put(6, 16'h0000);
        run_prog(200, 0);
        chk({mem[8'h50], mem[8'h51]} == 16'hBEEF, "R7 memory store", int'({mem[8'h50], mem[8'h51]}), 'hBEEF);
        chk(out_cnt == 1 && out_vals[0] == 16'hBEEF, "R7 memory load", int'(out_vals[0]), 'hBEEF);
        chk({mem[254], mem[255]} == 16'h0000, "R9 console not in memory", int'({mem[254], mem[255]}), 0);

        // R8: console load stalls until valid
        fill(8'h00);
        put(0, 16'h09FE);
        put(2, 16'h11FE);
        put(4, 16'h0000);
        in_vals = '{16'h1357, 16'h0, 16'h0, 16'h0};
        run_prog(200, 9);
        chk(stall_cnt == 9, "R8 stall cycles", stall_cnt, 9);
        chk(out_cnt == 1 && out_vals[0] == 16'h1357, "R8 value after stall", int'(out_vals[0]), 'h1357);

        // R10 / R12: jump then move
        fill(8'h00);
        put(0, 16'h3B30);   // jmp 0x30 (field 1 nonzero, ignored)
        put(2, 16'h10FE);   // store R0 -> console (must be skipped)
        put(8'h30, 16'h0CFE); // load R4 <- console
        put(8'h32, 16'h5680); // move R6 <- R4
        put(8'h34, 16'h16FE); // store R6 -> console
        in_vals = '{16'h1234, 16'h0, 16'h0, 16'h0};
        run_prog(300, 0);
        chk(out_cnt == 1, "R10 jump skips fallthrough", out_cnt, 1);
        chk(out_vals[0] == 16'h1234, "R12 move copies", int'(out_vals[0]), 'h1234);

        // R11: conditional jumps over the value list
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 16; i++) begin
                fill(8'h00);
                put(0, 16'h09FE);
                put(2, (k == 0) ? 16'h4120 : 16'h4920);
                put(4, 16'h11FE);
                put(6, 16'h11FE);
                put(8'h20, 16'h11FE);
                in_vals = '{16'(vals[i]), 16'h0, 16'h0, 16'h0};
                run_prog(300, 0);
                tk = (k == 0) ? (vals[i] == 0) : (vals[i] < 0);
                chk(out_cnt == (tk ? 1 : 2) && out_vals[0] == 16'(vals[i]),
                    (k == 0) ? "R11 jump-if-zero" : "R11 jump-if-negative", out_cnt, tk ? 1 : 2);
            end
        end

        // R4 R5 R6: arithmetic sweep over all operand pairs
        for (int op = 3; op <= 6; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    fill(8'h00);
                    put(0, 16'h09FE);                    // load R1 <- console
                    put(2, 16'h0AFE);                    // load R2 <- console
                    put(4, 16'((op << 11) | 16'h0140));  // op R1, R2
                    put(6, 16'h11FE);                    // store R1 -> console
                    in_vals = '{16'(vals[i]), 16'(vals[j]), 16'h0, 16'h0};
                    run_prog(300, 0);
                    exp_alu(op, vals[i], vals[j], h, r);
                    ac = (out_cnt > 0) ? int'(out_vals[0]) : -1;
                    if (h) begin
                        chk(!timed_out && out_cnt == 0,
                            (op == 5) ? "R5 multiply overflow halt" :
                            (op == 6) ? "R6 divide halt" : "R4 add/sub overflow halt", ac, -1);
                    end else begin
                        chk(!timed_out && out_cnt == 1 && out_vals[0] == r[15:0],
                            (op == 5) ? "R5 multiply result" :
                            (op == 6) ? "R6 divide result" : "R4 add/sub result", ac, int'(r[15:0]));
                    end
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule